// File: doc/BRIEF.md
# Accelerator command and status front-end

This block is the register-level front-end of an arithmetic accelerator. A host reaches it through a simple single-cycle register port. Three words sit at the bottom of the map: control, status and a write-one-to-clear word for the sticky flags. Above them is a window onto a 1334-word operand RAM. The front-end checks each opcode as it is written and launches the engine with a one-cycle start pulse. It tracks busy, aborts commands that cannot run, and gives the RAM to the engine for as long as an operation is in flight.

The sequencer is a four-state machine. IDLE is the state in which a start is accepted. LAUNCH drives the engine start pulse for one cycle. RUN waits for the engine's done input. ABORT holds busy for a fixed number of cycles without starting the engine. The transitions are:
- start: IDLE to LAUNCH, for a start with a legal opcode.
- reject: IDLE to ABORT, for a start with an opcode that cannot run.
- kick: LAUNCH to RUN.
- finish: RUN to IDLE, when done arrives.
- expire: ABORT to IDLE, once the abort count runs out.

Four sticky flags are kept: completion, RAM conflict, bad address and bad operation. Each flag is ANDed with its own enable bit, and the results are ORed into one interrupt line. An init-ok bit follows the readiness of the random source.

Top module: `accel_cmd_frontend`

## Requirements
- R1: After reset, the control word reads 0 and the status word reads 0 apart from bit 1, which mirrors `restricted_mode`. `irq` is 0 and `eng_start` is 0.
- R2: Status bit 0 (init-ok) is set after `rng_ready` has been high for INIT_CYCLES consecutive cycles. It stays 0 while `rng_ready` is low, and once set it stays set.
- R3: The legal opcodes are 0x00, 0x01, 0x02, 0x0E, 0x20 and 0x26.
  - A control write (address 0x0) with bit 0 (enable) = 1 and an illegal opcode in bits [13:8] leaves the stored opcode unchanged and sets the bad-operation flag (status bit 21).
  - With enable = 0, any opcode is stored and no flag is raised.
- R4: While `restricted_mode` is 1 (reported as status bit 1), a control write with enable = 1 accepts only opcode 0x26. Any other opcode is refused and sets status bit 21.
- R5: A start is a control write with bit 1 = 1 and bit 0 = 1, made while init-ok is 1 and the block is idle. If the stored opcode is usable, the start causes all of the following:
  - a one-cycle `eng_start` pulse that carries the opcode on `eng_opcode`;
  - busy (status bit 16) set until `eng_done` arrives;
  - on completion, busy clears and the completion flag (status bit 17) is set.
  Control bit 1 always reads 0.
- R6: A start written while busy produces no further `eng_start`.
- R7: A start whose opcode is illegal, or is not 0x26 in restricted mode, never pulses `eng_start`. It holds busy for ABORT_CYCLES cycles, returns to idle, and sets status bit 21.
- R8: A write to the clear word (address 0x8) with a 1 in bit 17, 19, 20 or 21 clears the matching flag, and leaves the other flags alone. If a flag is set and cleared in the same cycle, it ends up set.
- R9: RAM word i (i < 1334) is at byte address 0x400 + 4*i. While idle the host can write it and read it back, whatever the enable bit holds. Read data, for registers and RAM alike, appears on `bus_rdata` in the cycle after the request.
- R10: A host RAM access made while busy has these effects:
  - a write is dropped;
  - a read returns 0;
  - the RAM-conflict flag (status bit 19) is set.
  During busy the engine port reads and writes the RAM.
- R11: A host access at or above the RAM window that is misaligned or beyond word 1333 sets the bad-address flag (status bit 20) and changes no RAM word.
- R12: `irq` is the OR, over the four flags, of each flag ANDed with its enable bit. The enable bits sit at the flag's bit position in the control word (17, 19, 20, 21).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| rng_ready | input | 1 | Random source delivers valid numbers |
| restricted_mode | input | 1 | Only opcode 0x26 allowed |
| eng_start | output | 1 | One-cycle engine launch pulse |
| eng_opcode | output | 6 | Opcode of the running operation |
| eng_done | input | 1 | Engine completion pulse |
| eng_ram_we | input | 1 | Engine RAM write enable |
| eng_ram_idx | input | IDX_W | Engine RAM word index |
| eng_ram_wdata | input | 32 | Engine RAM write data |
| eng_ram_rdata | output | 32 | Engine RAM read data, one cycle latency |
| irq | output | 1 | Combined interrupt |

## Verification
The clash that matters here is a flag being set and cleared in the same cycle: `eng_done` ends an operation while the host writes bit 17 of the clear word. The bench provokes this by driving the engine done input by hand and making the clear write in the same cycle. It then reads the status word, and passes the case only if the completion flag is set and busy has dropped. A second overlap is a host RAM access during an engine run. That case is judged by checking that the dropped write leaves the old word in place, and that the engine's own write is visible once the block is idle.

// File: rtl/afe_pkg.sv
package afe_pkg;

    localparam int OP_W       = 6;
    localparam int N_LEGAL    = 6;
    localparam logic [OP_W-1:0] LIMITED_OP = 6'h26;
    localparam logic [OP_W*N_LEGAL-1:0] LEGAL_OPS =
        {6'h00, 6'h01, 6'h02, 6'h0E, 6'h20, 6'h26};

    // bit positions shared by control, status and clear words
    localparam int B_EN    = 0;
    localparam int B_START = 1;
    localparam int B_OPLO  = 8;
    localparam int B_INIT  = 0;
    localparam int B_LIM   = 1;
    localparam int B_BUSY  = 16;
    localparam int B_FIN   = 17;
    localparam int B_RAM   = 19;
    localparam int B_ADR   = 20;
    localparam int B_OPE   = 21;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_RUN,
        ST_ABORT
    } seq_state_t;

    typedef struct packed {
        logic ope;
        logic adr;
        logic ram;
        logic fin;
    } flags_t;

    function automatic logic op_legal(input logic [OP_W-1:0] op);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < N_LEGAL; i++) begin
            if (LEGAL_OPS[i*OP_W +: OP_W] == op) hit = 1'b1;
        end
        return hit;
    endfunction

    function automatic logic op_usable(input logic [OP_W-1:0] op, input logic limited);
        return op_legal(op) && !(limited && (op != LIMITED_OP));
    endfunction

endpackage

// File: rtl/afe_init_tracker.sv
module afe_init_tracker #(
    parameter int INIT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rng_ready,
    output logic init_ok
);
    localparam int CW = $clog2(INIT_CYCLES + 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            init_ok <= 1'b0;
        end else if (!init_ok) begin
            if (!rng_ready) begin
                run_cnt <= '0;
            end else if (run_cnt == CW'(INIT_CYCLES - 1)) begin
                init_ok <= 1'b1;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // R2
    no_init_while_unready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rng_ready && !init_ok) |=> !init_ok);

    // R2
    init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_ok |=> init_ok);

endmodule

// File: rtl/afe_seq_fsm.sv
module afe_seq_fsm
    import afe_pkg::*;
#(
    parameter int ABORT_CYCLES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_req,
    input  logic            start_ok,
    input  logic [OP_W-1:0] op_in,
    input  logic            eng_done,
    output logic            busy,
    output logic            eng_start,
    output logic [OP_W-1:0] eng_opcode,
    output logic            done_evt,
    output logic            abort_evt
);
    localparam int AW = $clog2(ABORT_CYCLES + 1);

    seq_state_t    state, state_nx;
    logic [AW-1:0] abort_cnt;

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_req) state_nx = start_ok ? ST_LAUNCH : ST_ABORT;
            end
            ST_LAUNCH: state_nx = ST_RUN;
            ST_RUN: begin
                if (eng_done) state_nx = ST_IDLE;
            end
            ST_ABORT: begin
                if (abort_cnt == AW'(ABORT_CYCLES - 1)) state_nx = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            abort_cnt  <= '0;
            eng_opcode <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start_req) begin
                abort_cnt  <= '0;
                eng_opcode <= op_in;
            end else if (state == ST_ABORT) begin
                abort_cnt <= abort_cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = 1'b1;
        eng_start = 1'b0;
        done_evt  = 1'b0;
        abort_evt = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy      = 1'b0;
                abort_evt = start_req && !start_ok;
            end
            ST_LAUNCH: eng_start = 1'b1;
            ST_RUN:    done_evt  = eng_done;
            ST_ABORT:  ;
        endcase
    end

    // R5
    start_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R5
    done_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> !busy);

    // R6
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_req) |=> !eng_start);

    // R7
    reject_no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_req && !start_ok) |=> (busy && !eng_start));

endmodule

// File: rtl/afe_op_ram.sv
module afe_op_ram #(
    parameter int RAM_WORDS = 1334,
    parameter int IDX_W     = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             host_req,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_q,
    input  logic             eng_we,
    input  logic [IDX_W-1:0] eng_idx,
    input  logic [31:0]      eng_wdata,
    output logic [31:0]      eng_q
);
    logic [31:0] mem [RAM_WORDS];
    logic        eng_ok;

    assign eng_ok = 32'(eng_idx) < RAM_WORDS;

    // single write port: engine owns it while busy, host otherwise
    always_ff @(posedge clk) begin
        if (busy) begin
            if (eng_we && eng_ok) mem[eng_idx] <= eng_wdata;
        end else if (host_req && host_we) begin
            mem[host_idx] <= host_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_q <= '0;
            eng_q  <= '0;
        end else begin
            if (host_req && !host_we) host_q <= busy ? '0 : mem[host_idx];
            eng_q <= (busy && eng_ok) ? mem[eng_idx] : '0;
        end
    end

    // R10
    blocked_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_req && !host_we) |=> (host_q == '0));

    // R11
    host_idx_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_req |-> (32'(host_idx) < RAM_WORDS));

endmodule

// File: rtl/accel_cmd_frontend.sv
module accel_cmd_frontend
    import afe_pkg::*;
#(
    parameter int RAM_WORDS    = 1334,
    parameter int ADDR_W       = 13,
    parameter int RAM_BASE     = 'h400,
    parameter int INIT_CYCLES  = 8,
    parameter int ABORT_CYCLES = 4,
    localparam int IDX_W       = $clog2(RAM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rng_ready,
    input  logic              restricted_mode,
    output logic              eng_start,
    output logic [OP_W-1:0]   eng_opcode,
    input  logic              eng_done,
    input  logic              eng_ram_we,
    input  logic [IDX_W-1:0]  eng_ram_idx,
    input  logic [31:0]       eng_ram_wdata,
    output logic [31:0]       eng_ram_rdata,
    output logic              irq
);
    localparam int WW = ADDR_W - 2;

    // ---------------- address decode ----------------
    logic [WW-1:0] word_addr, win_off;
    logic          aligned, wr_any, rd_any;
    logic          hit_ctrl, hit_stat, hit_clr, in_win, ram_hit;

    assign word_addr = bus_addr[ADDR_W-1:2];
    assign aligned   = (bus_addr[1:0] == 2'b00);
    assign wr_any    = bus_sel && bus_wr;
    assign rd_any    = bus_sel && !bus_wr;
    assign hit_ctrl  = aligned && (word_addr == WW'(0));
    assign hit_stat  = aligned && (word_addr == WW'(1));
    assign hit_clr   = aligned && (word_addr == WW'(2));
    assign in_win    = word_addr >= WW'(RAM_BASE / 4);
    assign win_off   = word_addr - WW'(RAM_BASE / 4);
    assign ram_hit   = aligned && in_win && (32'(win_off) < RAM_WORDS);

    // ---------------- control state ----------------
    logic            ctl_en;
    logic [OP_W-1:0] ctl_op;
    flags_t          ctl_ie;
    flags_t          flags, flag_set, flag_clr;

    logic            init_ok, busy, done_evt, abort_evt;
    logic            ctl_wr, en_new, op_reject, start_req, start_ok;
    logic [OP_W-1:0] op_new, op_eff;

    assign ctl_wr    = wr_any && hit_ctrl;
    assign en_new    = bus_wdata[B_EN];
    assign op_new    = bus_wdata[B_OPLO +: OP_W];
    assign op_reject = ctl_wr && en_new && !op_usable(op_new, restricted_mode);
    assign op_eff    = (ctl_wr && !op_reject) ? op_new : ctl_op;
    assign start_req = ctl_wr && bus_wdata[B_START] && en_new && init_ok;
    assign start_ok  = op_usable(op_eff, restricted_mode);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en <= 1'b0;
            ctl_op <= '0;
            ctl_ie <= '0;
        end else if (ctl_wr) begin
            ctl_en     <= en_new;
            ctl_op     <= op_eff;
            ctl_ie.fin <= bus_wdata[B_FIN];
            ctl_ie.ram <= bus_wdata[B_RAM];
            ctl_ie.adr <= bus_wdata[B_ADR];
            ctl_ie.ope <= bus_wdata[B_OPE];
        end
    end

    // ---------------- sticky flags ----------------
    always_comb begin
        flag_set.fin = done_evt;
        flag_set.ram = bus_sel && ram_hit && busy;
        flag_set.adr = bus_sel && in_win && !ram_hit;
        flag_set.ope = op_reject || abort_evt;
        flag_clr     = '0;
        if (wr_any && hit_clr) begin
            flag_clr.fin = bus_wdata[B_FIN];
            flag_clr.ram = bus_wdata[B_RAM];
            flag_clr.adr = bus_wdata[B_ADR];
            flag_clr.ope = bus_wdata[B_OPE];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~flag_clr) | flag_set;
    end

    assign irq = |(flags & ctl_ie);

    // ---------------- sub-blocks ----------------
    afe_init_tracker #(.INIT_CYCLES(INIT_CYCLES)) u_init (
        .clk       (clk),
        .rst_n     (rst_n),
        .rng_ready (rng_ready),
        .init_ok   (init_ok)
    );

    afe_seq_fsm #(.ABORT_CYCLES(ABORT_CYCLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .start_ok   (start_ok),
        .op_in      (op_eff),
        .eng_done   (eng_done),
        .busy       (busy),
        .eng_start  (eng_start),
        .eng_opcode (eng_opcode),
        .done_evt   (done_evt),
        .abort_evt  (abort_evt)
    );

    logic [31:0] ram_q;

    afe_op_ram #(.RAM_WORDS(RAM_WORDS), .IDX_W(IDX_W)) u_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .host_req   (bus_sel && ram_hit),
        .host_we    (bus_wr),
        .host_idx   (win_off[IDX_W-1:0]),
        .host_wdata (bus_wdata),
        .host_q     (ram_q),
        .eng_we     (eng_ram_we),
        .eng_idx    (eng_ram_idx),
        .eng_wdata  (eng_ram_wdata),
        .eng_q      (eng_ram_rdata)
    );

    // ---------------- read path ----------------
    logic [31:0] ctrl_word, stat_word, reg_q;
    logic        rd_ram;

    always_comb begin
        ctrl_word                  = '0;
        ctrl_word[B_EN]            = ctl_en;
        ctrl_word[B_OPLO +: OP_W]  = ctl_op;
        ctrl_word[B_FIN]           = ctl_ie.fin;
        ctrl_word[B_RAM]           = ctl_ie.ram;
        ctrl_word[B_ADR]           = ctl_ie.adr;
        ctrl_word[B_OPE]           = ctl_ie.ope;
        stat_word                  = '0;
        stat_word[B_INIT]          = init_ok;
        stat_word[B_LIM]           = restricted_mode;
        stat_word[B_BUSY]          = busy;
        stat_word[B_FIN]           = flags.fin;
        stat_word[B_RAM]           = flags.ram;
        stat_word[B_ADR]           = flags.adr;
        stat_word[B_OPE]           = flags.ope;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ram <= 1'b0;
            reg_q  <= '0;
        end else if (rd_any) begin
            rd_ram <= ram_hit;
            reg_q  <= hit_ctrl ? ctrl_word : (hit_stat ? stat_word : '0);
        end
    end

    assign bus_rdata = rd_ram ? ram_q : reg_q;

    // R3
    op_reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_reject |=> ($stable(ctl_op) && flags.ope));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt && flag_clr.fin) |=> flags.fin);

    // R11
    addr_err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && in_win && !aligned) |=> flags.adr);

endmodule

// File: tb/test_accel_cmd_frontend.sv
module test_accel_cmd_frontend;
    localparam int RAM_WORDS = 1334;
    localparam int ADDR_W    = 13;
    localparam int INIT_CYC  = 8;
    localparam int ABORT_CYC = 4;
    localparam int IDX_W     = $clog2(RAM_WORDS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              rng_ready = 1'b0, restricted_mode = 1'b0;
    logic              eng_start;
    logic [5:0]        eng_opcode;
    logic              eng_done = 1'b0;
    logic              eng_ram_we = 1'b0;
    logic [IDX_W-1:0]  eng_ram_idx = '0;
    logic [31:0]       eng_ram_wdata = '0;
    logic [31:0]       eng_ram_rdata;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    int starts_seen = 0;
    logic [5:0] last_op = '0;
    bit stub_en = 1'b1;

    always #10 clk = ~clk;

    accel_cmd_frontend #(
        .RAM_WORDS(RAM_WORDS), .ADDR_W(ADDR_W),
        .INIT_CYCLES(INIT_CYC), .ABORT_CYCLES(ABORT_CYC)
    ) i_accel_cmd_frontend (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rng_ready(rng_ready), .restricted_mode(restricted_mode),
        .eng_start(eng_start), .eng_opcode(eng_opcode), .eng_done(eng_done),
        .eng_ram_we(eng_ram_we), .eng_ram_idx(eng_ram_idx),
        .eng_ram_wdata(eng_ram_wdata), .eng_ram_rdata(eng_ram_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [ADDR_W-1:0] waddr(input int i);
        return ADDR_W'(32'h400 + 4 * i);
    endfunction

    function automatic logic legal(input int op);
        return op == 'h00 || op == 'h01 || op == 'h02 || op == 'h0E || op == 'h20 || op == 'h26;
    endfunction

    function automatic logic [31:0] pat(input int i);
        return 32'(i) * 32'h9E37_79B1 + 32'h5A5A_0000;
    endfunction

    task automatic wait_idle();
        logic [31:0] s;
        for (int k = 0; k < 100; k++) begin
            bread(ADDR_W'(4), s);
            if (!s[16]) break;
        end
    endtask

    // stub engine: 20 cycles per operation, writes word 5 near the end
    initial begin
        int pend;
        pend = 0;
        forever begin
            @(negedge clk);
            if (stub_en) begin
                eng_done = 1'b0;
                eng_ram_we = 1'b0;
                if (eng_start) begin
                    starts_seen++;
                    last_op = eng_opcode;
                    pend = 20;
                end else if (pend > 0) begin
                    pend--;
                    if (pend == 2) begin
                        eng_ram_we = 1'b1; eng_ram_idx = IDX_W'(5);
                        eng_ram_wdata = 32'hE000_0000 | 32'(last_op);
                    end
                    if (pend == 0) eng_done = 1'b1;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [5:0]  prev;
        int          s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bread(ADDR_W'(0), d); chk("R1 ctrl", d, 0);
        bread(ADDR_W'(4), d); chk("R1 status", d, 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 eng_start", 32'(eng_start), 0);

        // R2 init-ok
        repeat (20) @(negedge clk);
        bread(ADDR_W'(4), d); chk("R2 init low while unready", 32'(d[0]), 0);
        rng_ready = 1'b1;
        repeat (6) @(negedge clk);
        bread(ADDR_W'(4), d); chk("R2 init not yet", 32'(d[0]), 0);
        bread(ADDR_W'(4), d); chk("R2 init set", 32'(d[0]), 1);

        // R9 full RAM sweep with enable 0
        bwrite(ADDR_W'(0), 32'h0);
        for (int i = 0; i < RAM_WORDS; i++) bwrite(waddr(i), pat(i));
        for (int i = 0; i < RAM_WORDS; i++) begin
            bread(waddr(i), d); chk("R9 ram readback", d, pat(i));
        end

        // R11 beyond last word and misaligned
        bwrite(waddr(RAM_WORDS), 32'hBAD0_BAD0);
        bread(ADDR_W'(4), d); chk("R11 addr flag", 32'(d[20]), 1);
        bread(waddr(RAM_WORDS - 1), d); chk("R11 last word kept", d, pat(RAM_WORDS - 1));
        bwrite(ADDR_W'(8), 32'(1) << 20);
        bwrite(waddr(7) + ADDR_W'(2), 32'h1111_2222);
        bread(ADDR_W'(4), d); chk("R11 misaligned flag", 32'(d[20]), 1);
        bread(waddr(7), d); chk("R11 misaligned no write", d, pat(7));

        // R3 opcode sweep with enable 1
        bwrite(ADDR_W'(0), 32'h0000_0100);
        prev = 6'h01;
        for (int op = 0; op < 64; op++) begin
            bwrite(ADDR_W'(0), 32'h1 | (32'(op) << 8));
            if (legal(op)) prev = 6'(op);
            bread(ADDR_W'(0), d); chk("R3 opcode field", 32'(d[13:8]), 32'(prev));
            bread(ADDR_W'(4), d); chk("R3 op error flag", 32'(d[21]), 32'(!legal(op)));
            bwrite(ADDR_W'(8), 32'(1) << 21);
        end
        bwrite(ADDR_W'(0), 32'h0000_3F00);
        bread(ADDR_W'(0), d); chk("R3 enable0 stores any", 32'(d[13:8]), 32'h3F);
        bread(ADDR_W'(4), d); chk("R3 enable0 no error", 32'(d[21]), 0);

        // R4 restricted sweep
        restricted_mode = 1'b1;
        bwrite(ADDR_W'(0), 32'h0000_0000);
        prev = 6'h00;
        bread(ADDR_W'(4), d); chk("R4 status bit1", 32'(d[1]), 1);
        for (int op = 0; op < 64; op++) begin
            bwrite(ADDR_W'(0), 32'h1 | (32'(op) << 8));
            if (op == 'h26) prev = 6'h26;
            bread(ADDR_W'(0), d); chk("R4 opcode field", 32'(d[13:8]), 32'(prev));
            bread(ADDR_W'(4), d); chk("R4 op error flag", 32'(d[21]), 32'(op != 'h26));
            bwrite(ADDR_W'(8), 32'(1) << 21);
        end
        restricted_mode = 1'b0;

        // R5 / R6 / R10 normal run
        bwrite(waddr(3), 32'h1234_5678);
        s0 = starts_seen;
        bwrite(ADDR_W'(0), 32'h0000_0E03);
        bread(ADDR_W'(4), d); chk("R5 busy set", 32'(d[16]), 1);
        bwrite(ADDR_W'(0), 32'h0000_0E03);
        bwrite(waddr(3), 32'hDEAD_BEEF);
        bread(waddr(3), d); chk("R10 blocked read zero", d, 0);
        bread(ADDR_W'(4), d); chk("R10 ram flag", 32'(d[19]), 1);
        wait_idle();
        bread(ADDR_W'(4), d);
        chk("R5 busy clear", 32'(d[16]), 0);
        chk("R5 completion flag", 32'(d[17]), 1);
        chk("R6 single launch", 32'(starts_seen - s0), 1);
        chk("R5 opcode to engine", 32'(last_op), 32'h0E);
        bread(ADDR_W'(0), d); chk("R5 start reads 0", 32'(d[1]), 0);
        bread(waddr(3), d); chk("R10 dropped write", d, 32'h1234_5678);
        bread(waddr(5), d); chk("R10 engine write", d, 32'hE000_000E);

        // R7 abort of an illegal start
        s0 = starts_seen;
        bwrite(ADDR_W'(0), 32'h0000_3F00);
        bwrite(ADDR_W'(0), 32'h0000_3F03);
        bread(ADDR_W'(4), d); chk("R7 busy in abort", 32'(d[16]), 1);
        bread(ADDR_W'(4), d); chk("R7 busy late abort", 32'(d[16]), 1);
        bread(ADDR_W'(4), d); chk("R7 abort done", 32'(d[16]), 0);
        chk("R7 op error", 32'(d[21]), 1);
        chk("R7 no launch", 32'(starts_seen - s0), 0);

        // R12 interrupt enables with all four flags set
        bread(ADDR_W'(4), d); chk("R12 all flags", d & 32'h003A_0000, 32'h003A_0000);
        for (int k = 0; k < 16; k++) begin
            bwrite(ADDR_W'(0), (32'(k & 1) << 17) | (32'((k >> 1) & 1) << 19) |
                               (32'((k >> 2) & 1) << 20) | (32'((k >> 3) & 1) << 21));
            chk("R12 irq", 32'(irq), 32'(k != 0));
        end

        // R8 individual clears
        bwrite(ADDR_W'(8), 32'(1) << 17);
        bread(ADDR_W'(4), d); chk("R8 clear fin", d & 32'h003A_0000, 32'h0038_0000);
        bwrite(ADDR_W'(8), 32'(1) << 19);
        bread(ADDR_W'(4), d); chk("R8 clear ram", d & 32'h003A_0000, 32'h0030_0000);
        bwrite(ADDR_W'(8), 32'(1) << 20);
        bread(ADDR_W'(4), d); chk("R8 clear adr", d & 32'h003A_0000, 32'h0020_0000);
        chk("R12 irq one flag", 32'(irq), 1);
        bwrite(ADDR_W'(8), 32'(1) << 21);
        bread(ADDR_W'(4), d); chk("R8 clear ope", d & 32'h003A_0000, 0);
        chk("R12 irq none", 32'(irq), 0);

        // R8 set and clear in the same cycle
        stub_en = 1'b0;
        @(negedge clk); eng_done = 1'b0; eng_ram_we = 1'b0;
        bwrite(ADDR_W'(0), 32'h0000_2603);
        repeat (3) @(negedge clk);
        eng_done = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(8); bus_wdata = 32'(1) << 17;
        @(negedge clk);
        eng_done = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        bread(ADDR_W'(4), d);
        chk("R8 set wins", 32'(d[17]), 1);
        chk("R5 done frees", 32'(d[16]), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule